// File: doc/BRIEF.md
# Sync Frequency Measurement Counters

This block measures the line rate and the frame rate of a display timing source and keeps the results in registers for a host to read. The line measurement times a window that spans a fixed number of horizontal sync periods, 64 by default. It counts ticks of a 2 MHz time base, which is the 12 MHz system clock divided by 6. The frame measurement times the gap between two vertical sync pulses. It counts ticks of a 62.5 kHz time base, which is the clock divided by 192. Because the result is a tick count, it is the reciprocal of the frequency. At the default settings, the line result is 128000000/f_h minus 1 and the frame result is 62500/f_v.

The vertical input is whichever vertical sync the surrounding logic selected: either the separate sync or the one extracted from composite sync. A presence flag comes with it. While that flag is high, the line result is published once per frame, on the vertical edge. While it is low, the line result is published after every window. Each result carries an overflow bit. Each result also has a sticky change flag that is cleared by a write-one pulse. Both sync inputs pass through a polarity inverter, so that counting always starts and ends on the edge where the sync becomes active.

All pins are plain control and status signals. Results are level outputs that hold until the next load, so there is no stream and no back-pressure.

Top module: `sync_freq_meter`

## Requirements
- R1: While reset is held, and after it is released until the first load, both counts, both overflow bits and both change flags read 0.
- R2: An active edge on a sync input is a clock cycle in which (input XOR its invert pin) samples 1 after sampling 0 in the cycle before. A sync that is already active when reset is released does not count as an edge until it has gone inactive and become active again.
- R3: A line window starts on an active horizontal edge and ends on the H_PERIODS-th horizontal edge after it. That ending edge also starts the next window. For a window of L clock cycles, the line result is floor((L-1)/H_DIV).
- R4: The first active vertical edge after reset only starts timing. Every later vertical edge loads a frame result of 1 + floor((L-1)/V_DIV), where L is the number of cycles since the previous vertical edge. That edge then restarts timing.
- R5: While the presence pin is 1, the line registers load only on active vertical edges. They take the most recent window result that finished at least one cycle before the edge. Nothing loads if no window has finished since reset.
- R6: While the presence pin is 0, the line registers load at the end of every window with that window's result, whatever the vertical input does.
- R7: A result that would exceed the all-ones value of its count width loads as all ones with its overflow bit at 1. Otherwise its overflow bit loads as 0.
- R8: A change flag is set by a load whose value differs from the value currently held, or whose overflow bit is 1. Once set, it stays at 1 until its clear pin is 1 in a cycle with no setting load. A setting load wins over a clear in the same cycle.
- R9: Counts, overflow bits and flags change only in the clock cycle that follows the edge cycle that caused the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 12 MHz nominal |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Selected vertical sync (separate or extracted) |
| hsync_inv_i | input | 1 | 1 inverts the horizontal sync before edge detection |
| vsync_inv_i | input | 1 | 1 inverts the vertical sync before edge detection |
| vsync_present_i | input | 1 | 1 when the selected vertical sync is present |
| h_chg_clr_i | input | 1 | Write-one clear of the line change flag |
| v_chg_clr_i | input | 1 | Write-one clear of the frame change flag |
| h_count_o | output | H_WIDTH | Latched line result |
| h_ovf_o | output | 1 | Line result overflow |
| v_count_o | output | V_WIDTH | Latched frame result |
| v_ovf_o | output | 1 | Frame result overflow |
| h_chg_o | output | 1 | Line change flag |
| v_chg_o | output | 1 | Frame change flag |

## Verification
The bench drives line periods that are exact multiples of the prescaler and periods that are not. This catches an off-by-one in the tick count or in the window length, which would shift every result by one. It switches the presence pin in both directions while both syncs are running, and it inverts both polarities mid-run. A design that loaded on the wrong event, or that took the line value from the live counter instead of the held one, would disagree on the cycle of the load. It drives periods long enough to saturate each counter; a counter that wrapped would show a small value with no overflow. It also pulses the clear pins repeatedly, so that some pulses land on a setting load and check that the set wins.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

  localparam int unsigned NUM_SYNC   = 2;
  localparam int unsigned SYNC_H_IDX = 0;
  localparam int unsigned SYNC_V_IDX = 1;

  // width of a counter that must hold values 0 .. n-1
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sfm_edge.sv
module sfm_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic invert_i,
  output logic edge_o
);
  logic norm;
  logic prev;

  assign norm   = sync_i ^ invert_i;
  assign edge_o = norm & ~prev;

  // prev starts at 1 so that a sync already active at reset is not an edge
  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= norm;
  end
endmodule

// File: rtl/sfm_interval_counter.sv
module sfm_interval_counter
  import sfm_pkg::*;
#(
  parameter int unsigned W    = 14,
  parameter int unsigned DIV  = 6,
  parameter int unsigned INIT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart_i,
  output logic [W-1:0] count_o,
  output logic         ovf_o
);
  localparam int unsigned PW       = idx_width(DIV);
  localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);
  localparam logic [W-1:0]  CNT_MAX  = {W{1'b1}};
  localparam logic [W-1:0]  CNT_INIT = W'(INIT);

  logic [PW-1:0] pre;
  logic          tick;

  assign tick = (pre == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre     <= '0;
      count_o <= CNT_INIT;
      ovf_o   <= 1'b0;
    end else if (restart_i) begin
      pre     <= '0;
      count_o <= CNT_INIT;
      ovf_o   <= 1'b0;
    end else if (tick) begin
      pre <= '0;
      if (count_o == CNT_MAX) ovf_o   <= 1'b1;
      else                    count_o <= count_o + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end
endmodule

// File: rtl/sfm_result_reg.sv
module sfm_result_reg #(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] new_val_i,
  input  logic         new_ovf_i,
  input  logic         clr_i,
  output logic [W-1:0] val_o,
  output logic         ovf_o,
  output logic         chg_o
);
  logic set_chg;

  assign set_chg = load_i & ((new_val_i != val_o) | new_ovf_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_o <= '0;
      ovf_o <= 1'b0;
      chg_o <= 1'b0;
    end else begin
      if (load_i) begin
        val_o <= new_val_i;
        ovf_o <= new_ovf_i;
      end
      if (set_chg)    chg_o <= 1'b1;
      else if (clr_i) chg_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_freq_meter.sv
module sync_freq_meter
  import sfm_pkg::*;
#(
  parameter int unsigned H_WIDTH   = 14,
  parameter int unsigned V_WIDTH   = 12,
  parameter int unsigned H_DIV     = 6,
  parameter int unsigned V_DIV     = 192,
  parameter int unsigned H_PERIODS = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hsync_i,
  input  logic               vsync_i,
  input  logic               hsync_inv_i,
  input  logic               vsync_inv_i,
  input  logic               vsync_present_i,
  input  logic               h_chg_clr_i,
  input  logic               v_chg_clr_i,
  output logic [H_WIDTH-1:0] h_count_o,
  output logic               h_ovf_o,
  output logic [V_WIDTH-1:0] v_count_o,
  output logic               v_ovf_o,
  output logic               h_chg_o,
  output logic               v_chg_o
);
  localparam int unsigned EW = idx_width(H_PERIODS);
  localparam logic [EW-1:0] LAST_EDGE = EW'(H_PERIODS - 1);

  // ---------------- polarity and edge detection ----------------
  logic [NUM_SYNC-1:0] sync_raw, sync_inv, sync_edge;
  assign sync_raw[SYNC_H_IDX] = hsync_i;
  assign sync_raw[SYNC_V_IDX] = vsync_i;
  assign sync_inv[SYNC_H_IDX] = hsync_inv_i;
  assign sync_inv[SYNC_V_IDX] = vsync_inv_i;

  for (genvar g = 0; g < NUM_SYNC; g++) begin : g_edge
    sfm_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_i   (sync_raw[g]),
      .invert_i (sync_inv[g]),
      .edge_o   (sync_edge[g])
    );
  end

  logic h_edge, v_edge;
  assign h_edge = sync_edge[SYNC_H_IDX];
  assign v_edge = sync_edge[SYNC_V_IDX];

  // ---------------- line window sequencing ----------------
  logic          h_run;
  logic [EW-1:0] h_edges;
  logic          h_win_end, h_restart;

  assign h_win_end = h_edge & h_run & (h_edges == LAST_EDGE);
  assign h_restart = h_edge & (~h_run | (h_edges == LAST_EDGE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_run   <= 1'b0;
      h_edges <= '0;
    end else if (h_edge) begin
      if (h_restart) begin
        h_run   <= 1'b1;
        h_edges <= '0;
      end else begin
        h_edges <= h_edges + 1'b1;
      end
    end
  end

  logic [H_WIDTH-1:0] h_cnt;
  logic               h_cnt_ovf;

  sfm_interval_counter #(.W(H_WIDTH), .DIV(H_DIV), .INIT(0)) u_hcnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (h_restart),
    .count_o   (h_cnt),
    .ovf_o     (h_cnt_ovf)
  );

  // most recent finished window, held for once-per-frame publishing
  logic [H_WIDTH-1:0] h_meas_val;
  logic               h_meas_ovf;
  logic               h_meas_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_meas_val <= '0;
      h_meas_ovf <= 1'b0;
      h_meas_vld <= 1'b0;
    end else if (h_win_end) begin
      h_meas_val <= h_cnt;
      h_meas_ovf <= h_cnt_ovf;
      h_meas_vld <= 1'b1;
    end
  end

  logic               h_load;
  logic [H_WIDTH-1:0] h_new_val;
  logic               h_new_ovf;

  always_comb begin
    if (vsync_present_i) begin
      h_load    = v_edge & h_meas_vld;
      h_new_val = h_meas_val;
      h_new_ovf = h_meas_ovf;
    end else begin
      h_load    = h_win_end;
      h_new_val = h_cnt;
      h_new_ovf = h_cnt_ovf;
    end
  end

  sfm_result_reg #(.W(H_WIDTH)) u_hres (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (h_load),
    .new_val_i (h_new_val),
    .new_ovf_i (h_new_ovf),
    .clr_i     (h_chg_clr_i),
    .val_o     (h_count_o),
    .ovf_o     (h_ovf_o),
    .chg_o     (h_chg_o)
  );

  // ---------------- frame interval ----------------
  logic v_run;
  logic v_load;

  assign v_load = v_edge & v_run;

  always_ff @(posedge clk) begin
    if (!rst_n)      v_run <= 1'b0;
    else if (v_edge) v_run <= 1'b1;
  end

  logic [V_WIDTH-1:0] v_cnt;
  logic               v_cnt_ovf;

  sfm_interval_counter #(.W(V_WIDTH), .DIV(V_DIV), .INIT(1)) u_vcnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (v_edge),
    .count_o   (v_cnt),
    .ovf_o     (v_cnt_ovf)
  );

  sfm_result_reg #(.W(V_WIDTH)) u_vres (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (v_load),
    .new_val_i (v_cnt),
    .new_ovf_i (v_cnt_ovf),
    .clr_i     (v_chg_clr_i),
    .val_o     (v_count_o),
    .ovf_o     (v_ovf_o),
    .chg_o     (v_chg_o)
  );
endmodule

// File: rtl/sfm_checker.sv
module sfm_checker #(
  parameter int unsigned H_WIDTH = 14,
  parameter int unsigned V_WIDTH = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vsync_present_i,
  input logic               h_chg_clr_i,
  input logic               v_chg_clr_i,
  input logic               h_load,
  input logic               v_load,
  input logic               v_edge,
  input logic [H_WIDTH-1:0] h_count_o,
  input logic               h_ovf_o,
  input logic [V_WIDTH-1:0] v_count_o,
  input logic               v_ovf_o,
  input logic               h_chg_o,
  input logic               v_chg_o
);
  // R7
  h_ovf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_ovf_o |-> (h_count_o == {H_WIDTH{1'b1}}));

  // R7
  v_ovf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_ovf_o |-> (v_count_o == {V_WIDTH{1'b1}}));

  // R9
  h_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !h_load |=> ($stable(h_count_o) && $stable(h_ovf_o)));

  // R9
  v_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v_load |=> ($stable(v_count_o) && $stable(v_ovf_o)));

  // R5
  h_frame_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync_present_i && h_load) |-> v_edge);

  // R8
  h_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_chg_clr_i && !h_load) |=> !h_chg_o);

  // R8
  v_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_chg_clr_i && !v_load) |=> !v_chg_o);

  // R8
  v_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(v_chg_o) |-> $past(v_load));
endmodule

bind sync_freq_meter sfm_checker #(.H_WIDTH(H_WIDTH), .V_WIDTH(V_WIDTH)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .vsync_present_i (vsync_present_i),
  .h_chg_clr_i     (h_chg_clr_i),
  .v_chg_clr_i     (v_chg_clr_i),
  .h_load          (h_load),
  .v_load          (v_load),
  .v_edge          (v_edge),
  .h_count_o       (h_count_o),
  .h_ovf_o         (h_ovf_o),
  .v_count_o       (v_count_o),
  .v_ovf_o         (v_ovf_o),
  .h_chg_o         (h_chg_o),
  .v_chg_o         (v_chg_o)
);

// File: tb/sim_sync_freq_meter.sv
`timescale 1ns/1ps
module sim_sync_freq_meter;
  localparam int HW = 8, VW = 8, HD = 3, VD = 5, HP = 4;
  localparam int HMAX = (1 << HW) - 1;
  localparam int VMAX = (1 << VW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_i = 1'b0, vsync_i = 1'b0;
  logic hsync_inv_i = 1'b0, vsync_inv_i = 1'b0;
  logic vsync_present_i = 1'b0;
  logic h_chg_clr_i = 1'b0, v_chg_clr_i = 1'b0;
  logic [HW-1:0] h_count_o;
  logic [VW-1:0] v_count_o;
  logic h_ovf_o, v_ovf_o, h_chg_o, v_chg_o;

  always #4 clk = ~clk;

  sync_freq_meter #(.H_WIDTH(HW), .V_WIDTH(VW), .H_DIV(HD), .V_DIV(VD),
                    .H_PERIODS(HP)) u0 (
    .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .vsync_i(vsync_i),
    .hsync_inv_i(hsync_inv_i), .vsync_inv_i(vsync_inv_i),
    .vsync_present_i(vsync_present_i),
    .h_chg_clr_i(h_chg_clr_i), .v_chg_clr_i(v_chg_clr_i),
    .h_count_o(h_count_o), .h_ovf_o(h_ovf_o), .v_count_o(v_count_o),
    .v_ovf_o(v_ovf_o), .h_chg_o(h_chg_o), .v_chg_o(v_chg_o));

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int cyc = 0;
  bit hprev, vprev, hrun, vrun, hm_vld;
  int hstart, vstart, hedges, hm_v, hm_o;
  int e_hc, e_ho, e_hf, e_vc, e_vo, e_vf;

  always @(posedge clk) begin
    bit hn, vn, he, ve, hdone, hload;
    int len, t, hdv, hdo, lv, lo;
    if (!rst_n) begin
      hprev = 1; vprev = 1; hrun = 0; vrun = 0; hm_vld = 0;
      hstart = 0; vstart = 0; hedges = 0; hm_v = 0; hm_o = 0;
      e_hc = 0; e_ho = 0; e_hf = 0; e_vc = 0; e_vo = 0; e_vf = 0;
    end else begin
      hn = hsync_i ^ hsync_inv_i; he = hn && !hprev; hprev = hn;  // R2
      vn = vsync_i ^ vsync_inv_i; ve = vn && !vprev; vprev = vn;
      hdone = 0; hdv = 0; hdo = 0;
      if (he) begin
        if (!hrun) begin
          hrun = 1; hstart = cyc; hedges = 0;
        end else if (hedges == HP - 1) begin
          len = cyc - hstart; t = (len - 1) / HD;          // R3
          hdo = (t > HMAX); hdv = hdo ? HMAX : t;          // R7
          hdone = 1; hstart = cyc; hedges = 0;
        end else hedges++;
      end
      hload = 0; lv = 0; lo = 0;
      if (vsync_present_i) begin                           // R5
        if (ve && hm_vld) begin hload = 1; lv = hm_v; lo = hm_o; end
      end else if (hdone) begin                            // R6
        hload = 1; lv = hdv; lo = hdo;
      end
      if (hdone) begin hm_v = hdv; hm_o = hdo; hm_vld = 1; end
      if (hload) begin                                     // R8
        if (lv != e_hc || lo != 0) e_hf = 1;
        else if (h_chg_clr_i) e_hf = 0;
        e_hc = lv; e_ho = lo;
      end else if (h_chg_clr_i) e_hf = 0;
      if (ve) begin
        if (vrun) begin
          len = cyc - vstart; t = 1 + (len - 1) / VD;      // R4
          lo = (t > VMAX); lv = lo ? VMAX : t;
          if (lv != e_vc || lo != 0) e_vf = 1;
          else if (v_chg_clr_i) e_vf = 0;
          e_vc = lv; e_vo = lo;
        end else if (v_chg_clr_i) e_vf = 0;
        vrun = 1; vstart = cyc;
      end else if (v_chg_clr_i) e_vf = 0;
    end
    cyc++;
  end

  // compare on every clock, away from the active edge (R9 timing)
  always @(negedge clk) begin
    if (cyc > 0 && !finished) begin
      chk("R3 R5 R6 R9 h_count", int'(h_count_o), e_hc);
      chk("R7 h_ovf", int'(h_ovf_o), e_ho);
      chk("R8 h_chg", int'(h_chg_o), e_hf);
      chk("R4 R9 v_count", int'(v_count_o), e_vc);
      chk("R7 v_ovf", int'(v_ovf_o), e_vo);
      chk("R8 v_chg", int'(v_chg_o), e_vf);
    end
  end

  // ---------------- stimulus generators ----------------
  int h_per = 0, v_per = 0;

  initial forever begin
    if (h_per == 0) begin
      @(negedge clk); hsync_i = hsync_inv_i;
    end else begin
      for (int i = 0; i < h_per; i++) begin
        @(negedge clk); hsync_i = (i < 3) ^ hsync_inv_i;
      end
    end
  end

  initial forever begin
    if (v_per == 0) begin
      @(negedge clk); vsync_i = vsync_inv_i;
    end else begin
      for (int i = 0; i < v_per; i++) begin
        @(negedge clk); vsync_i = (i < 2) ^ vsync_inv_i;
      end
    end
  end

  task automatic run(input int n, input int clr_every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clr_every > 0 && (i % clr_every) == 0) begin
        h_chg_clr_i = 1; v_chg_clr_i = 1;
      end else begin
        h_chg_clr_i = 0; v_chg_clr_i = 0;
      end
    end
    @(negedge clk); h_chg_clr_i = 0; v_chg_clr_i = 0;
  endtask

  initial begin
    hsync_i = 1'b1;                  // sync active during reset (R2)
    h_per = 0;
    repeat (6) @(negedge clk);
    // R1: reset state
    chk("R1 reset h_count", int'(h_count_o), 0);
    chk("R1 reset v_count", int'(v_count_o), 0);
    chk("R1 reset flags", int'({h_chg_o, v_chg_o, h_ovf_o, v_ovf_o}), 0);
    rst_n = 1'b1;
    run(20, 0);
    chk("R1 idle after reset", int'(h_count_o), 0);
    // R3 R6: exact-multiple line period, no vertical
    h_per = 21; run(400, 0);
    chk("R3 exact period h_count", int'(h_count_o), (4 * 21 - 1) / HD);
    run(1, 1); run(200, 0);                 // R8 clear, steady: stays clear
    chk("R8 flag stays clear", int'(h_chg_o), 0);
    h_per = 25; run(400, 0);                // R8 change sets flag
    chk("R8 flag set on change", int'(h_chg_o), 1);
    run(300, 7);                            // clears colliding with loads
    // R4 R5: vertical present
    v_per = 400; vsync_present_i = 1; run(2500, 53);
    // R2: inverted polarity on both inputs
    hsync_inv_i = 1; vsync_inv_i = 1; run(2000, 0);
    // R7: line overflow
    h_per = 300; run(4000, 61);
    chk("R7 line overflow", int'(h_ovf_o), 1);
    h_per = 30; run(1500, 0);
    // R7: frame overflow
    v_per = 1500; run(5000, 97);
    chk("R7 frame overflow", int'(v_ovf_o), 1);
    // R6: presence low with vertical still running
    v_per = 333; vsync_present_i = 0; h_per = 23; run(3000, 41);
    vsync_present_i = 1; run(1500, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog R9 actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule